// File: doc/BRIEF.md
# Region Permission Gate for a Partitioned Byte Memory

This block decides whether each read or write request to a 512-byte memory may proceed. The memory is split into four 128-byte regions. The upper address bits select the region. Each region has a four-bit policy code. The first two bits say which passwords the region demands, and the last two bits choose its function mode: open, read-only, program-only (bits may only be cleared) or locked. The four codes are held in two 8-bit control registers, which are loaded through a dedicated configuration write port.

For each request strobe, the gate takes the address, the operation, the new byte, the byte currently stored, and three flags. The flags come from an external password unit and say whether the read, write or configuration password has been verified. One cycle later the gate reports grant or deny. Any denial comes with a no-acknowledge. A program-only write that tries to raise a bit also requests standby. The gate drives the memory write enable and the read-data strobe, so a refused operation never touches the array.

Top module: `region_access_gate`

## Requirements
- R1: The region index is `req_addr[8:7]`: 0x000–0x07F is region 0, 0x080–0x0FF is region 1, 0x100–0x17F is region 2, 0x180–0x1FF is region 3.
- R2: Control word 0 holds region 0's code in bits [3:0] and region 1's code in bits [7:4]. Control word 1 holds region 2 in bits [3:0] and region 3 in bits [7:4]. A configuration write loads `cfg_wdata` into the word picked by `cfg_sel`. Both words reset to 0x00.
- R3: In a code nibble, bit 3 set means the write password is required and bit 2 set means the read password is required. A read without `rd_pw_ok` is denied when bit 2 is set. A write without `wr_pw_ok` is denied when bit 3 is set.
- R4: Code bits [1:0] select the mode. 00 allows reads and writes. 10 allows reads and denies every write. 01 allows reads and program-only writes.
- R5: In mode 01, a write whose new byte has a 1 where the stored byte has a 0 is denied, with both `dec_nak` and `dec_standby` asserted. A write that only clears bits, or changes nothing, is granted.
- R6: In mode 11, reads and writes are granted only when `cfg_pw_ok` is set, whatever the other flags or the password bits.
- R7: A denied request asserts `dec_nak` and never asserts `mem_we` or `rd_data_valid`. A granted write asserts `mem_we`. A granted read asserts `rd_data_valid`.
- R8: All decision outputs appear exactly one clock after the cycle in which `req_valid` is sampled high, and they last one cycle. With no request, all decision outputs are low.
- R9: During reset all decision outputs are low. `dec_standby` is only asserted together with `dec_nak`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 1 | Control word select (0 or 1) |
| cfg_wdata | input | 8 | Control word value |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address |
| req_wdata | input | 8 | Byte to be written |
| req_old | input | 8 | Byte currently stored at the address |
| rd_pw_ok | input | 1 | Read password verified |
| wr_pw_ok | input | 1 | Write password verified |
| cfg_pw_ok | input | 1 | Configuration password verified |
| dec_valid | output | 1 | Decision strobe |
| dec_grant | output | 1 | Request permitted |
| dec_nak | output | 1 | No-acknowledge (request refused) |
| dec_standby | output | 1 | Standby request after a program-only violation |
| mem_we | output | 1 | Memory write enable |
| rd_data_valid | output | 1 | Read data strobe |

## Verification
The gate is tried with one configuration in which each region carries a different password/mode pair, and with requests that sit on both edges of every region. This separates a wrong address slice from a wrong nibble choice. Each password requirement is tried both with the matching flag present and with only the other flags present, which shows whether the read and write bits have been swapped. Program-only writes are tried with a pure clear, an unchanged byte and a single raised bit, so that a subset test written the wrong way round gives itself away. The locked region is tried with and without the configuration flag. A reload of the control words then shows that the codes follow the configuration port.

// File: rtl/rga_pkg.sv
package rga_pkg;
  typedef enum logic [1:0] {
    FN_OPEN   = 2'b00,
    FN_PROG   = 2'b01,
    FN_RONLY  = 2'b10,
    FN_LOCKED = 2'b11
  } fn_e;

  // nibble layout: [3] write password needed, [2] read password needed, [1:0] mode
  typedef struct packed {
    logic wr_pw;
    logic rd_pw;
    fn_e  fn;
  } code_t;

  typedef struct packed {
    logic grant;
    logic nak;
    logic standby;
  } verdict_t;
endpackage

// File: rtl/rga_ctrl_regs.sv
module rga_ctrl_regs #(
  parameter int NUM_REGIONS = 4,
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 4,
  localparam int PER_WORD   = DATA_W / CODE_W,
  localparam int NUM_WORDS  = NUM_REGIONS / PER_WORD,
  localparam int SEL_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [NUM_REGIONS*CODE_W-1:0] codes
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;
    logic              load_en;

    always_comb begin
      load_en = cfg_we && (cfg_sel == SEL_W'(g));
      word_d  = load_en ? cfg_wdata : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign codes[g*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/rga_region_sel.sv
module rga_region_sel
  import rga_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int NUM_REGIONS = 4,
  parameter int CODE_W      = 4,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_REGIONS*CODE_W-1:0] codes,
  output code_t                         code
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx  = addr[ADDR_W-1 -: IDX_W];
    code = code_t'(codes[idx*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/rga_policy.sv
module rga_policy
  import rga_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  code_t             code,
  input  logic              is_write,
  input  logic [DATA_W-1:0] new_byte,
  input  logic [DATA_W-1:0] old_byte,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic              cfg_ok,
  output verdict_t          verdict
);
  logic raises_bit;
  logic ok;
  logic stby;

  always_comb begin
    raises_bit = |(~old_byte & new_byte);
    ok   = 1'b0;
    stby = 1'b0;
    if (code.fn == FN_LOCKED) begin
      ok = cfg_ok;
    end else if (!is_write) begin
      ok = !code.rd_pw || rd_ok;
    end else if (code.wr_pw && !wr_ok) begin
      ok = 1'b0;
    end else begin
      unique case (code.fn)
        FN_OPEN:  ok = 1'b1;
        FN_RONLY: ok = 1'b0;
        FN_PROG: begin
          ok   = !raises_bit;
          stby = raises_bit;
        end
        default:  ok = 1'b0;
      endcase
    end
    verdict.grant   = ok;
    verdict.nak     = !ok;
    verdict.standby = stby;
  end
endmodule

// File: rtl/region_access_gate.sv
module region_access_gate
  import rga_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int NUM_REGIONS = 4,
  parameter int CODE_W      = 4,
  localparam int NUM_WORDS  = NUM_REGIONS / (DATA_W / CODE_W),
  localparam int SEL_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_old,
  input  logic              rd_pw_ok,
  input  logic              wr_pw_ok,
  input  logic              cfg_pw_ok,
  output logic              dec_valid,
  output logic              dec_grant,
  output logic              dec_nak,
  output logic              dec_standby,
  output logic              mem_we,
  output logic              rd_data_valid
);
  logic [NUM_REGIONS*CODE_W-1:0] codes;
  code_t    cur_code;
  verdict_t verdict;

  rga_ctrl_regs #(
    .NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W), .CODE_W(CODE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .codes(codes)
  );

  rga_region_sel #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .CODE_W(CODE_W)
  ) u_sel (
    .addr(req_addr), .codes(codes), .code(cur_code)
  );

  rga_policy #(.DATA_W(DATA_W)) u_policy (
    .code(cur_code), .is_write(req_write), .new_byte(req_wdata),
    .old_byte(req_old), .rd_ok(rd_pw_ok), .wr_ok(wr_pw_ok),
    .cfg_ok(cfg_pw_ok), .verdict(verdict)
  );

  logic valid_d, grant_d, nak_d, stby_d, we_d, rdv_d;

  always_comb begin
    valid_d = req_valid;
    grant_d = req_valid && verdict.grant;
    nak_d   = req_valid && verdict.nak;
    stby_d  = req_valid && verdict.standby;
    we_d    = grant_d && req_write;
    rdv_d   = grant_d && !req_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid     <= 1'b0;
      dec_grant     <= 1'b0;
      dec_nak       <= 1'b0;
      dec_standby   <= 1'b0;
      mem_we        <= 1'b0;
      rd_data_valid <= 1'b0;
    end else begin
      dec_valid     <= valid_d;
      dec_grant     <= grant_d;
      dec_nak       <= nak_d;
      dec_standby   <= stby_d;
      mem_we        <= we_d;
      rd_data_valid <= rdv_d;
    end
  end
endmodule

// File: rtl/rga_checker.sv
module rga_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_write,
  input logic dec_valid,
  input logic dec_grant,
  input logic dec_nak,
  input logic dec_standby,
  input logic mem_we,
  input logic rd_data_valid
);
  // R8
  decision_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);

  // R8
  quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid && !dec_grant && !dec_nak && !mem_we && !rd_data_valid);

  // R7
  deny_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_nak |-> !mem_we && !rd_data_valid && !dec_grant);

  // R7
  we_matches_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> dec_grant && $past(req_write));

  // R9
  standby_implies_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_standby |-> dec_nak && $past(req_write));

  // R7
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $onehot({dec_grant, dec_nak}));
endmodule

bind region_access_gate rga_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .dec_valid(dec_valid), .dec_grant(dec_grant), .dec_nak(dec_nak),
  .dec_standby(dec_standby), .mem_we(mem_we), .rd_data_valid(rd_data_valid)
);

// File: tb/region_access_gate_tb.sv
module region_access_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // vector: {wr, addr[8:0], wdata, old, rd_ok, wr_ok, cfg_ok, grant, nak, standby}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 9'h010, 8'h00, 8'h00, 3'b000, 3'b100}, // 0 R1 R4 open read
    {1'b1, 9'h07F, 8'hAA, 8'h00, 3'b000, 3'b100}, // 1 R1 R4 open write raising bits
    {1'b1, 9'h080, 8'h00, 8'hFF, 3'b101, 3'b010}, // 2 R3 write pw missing
    {1'b1, 9'h080, 8'h0F, 8'hFF, 3'b010, 3'b100}, // 3 R5 clear only
    {1'b1, 9'h0FF, 8'h10, 8'h0F, 3'b010, 3'b011}, // 4 R5 raise bit
    {1'b0, 9'h0C0, 8'h00, 8'h00, 3'b000, 3'b100}, // 5 R4 program mode read
    {1'b0, 9'h100, 8'h00, 8'h00, 3'b011, 3'b010}, // 6 R3 read pw missing
    {1'b0, 9'h17F, 8'h00, 8'h00, 3'b100, 3'b100}, // 7 R3 read pw present
    {1'b1, 9'h100, 8'h00, 8'hFF, 3'b110, 3'b010}, // 8 R4 read-only write
    {1'b0, 9'h180, 8'h00, 8'h00, 3'b110, 3'b010}, // 9 R6 locked no cfg
    {1'b1, 9'h1FF, 8'h55, 8'h00, 3'b001, 3'b100}, // 10 R6 locked with cfg
    {1'b0, 9'h180, 8'h00, 8'h00, 3'b001, 3'b100}, // 11 R6 locked read with cfg
    {1'b1, 9'h0A0, 8'h3C, 8'h3C, 3'b010, 3'b100}, // 12 R5 unchanged byte
    {1'b1, 9'h07F, 8'h00, 8'h00, 3'b000, 3'b100}  // 13 R1 region 0 upper edge
  };

  logic       clk, rst_n;
  logic       cfg_we, cfg_sel;
  logic [7:0] cfg_wdata;
  logic       req_valid, req_write;
  logic [8:0] req_addr;
  logic [7:0] req_wdata, req_old;
  logic       rd_pw_ok, wr_pw_ok, cfg_pw_ok;
  logic       dec_valid, dec_grant, dec_nak, dec_standby, mem_we, rd_data_valid;

  int total = 0;
  int bad   = 0;

  region_access_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_old(req_old),
    .rd_pw_ok(rd_pw_ok), .wr_pw_ok(wr_pw_ok), .cfg_pw_ok(cfg_pw_ok),
    .dec_valid(dec_valid), .dec_grant(dec_grant), .dec_nak(dec_nak),
    .dec_standby(dec_standby), .mem_we(mem_we), .rd_data_valid(rd_data_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {valid,grant,nak,stby,we,rdv} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {dec_valid, dec_grant, dec_nak, dec_standby, mem_we, rd_data_valid};
  endfunction

  task automatic cfg_write(input logic sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives a request at a falling edge, samples at the next falling edge
  task automatic request(input logic [31:0] v, input string req);
    logic [5:0] exp;
    @(negedge clk);
    req_valid = 1'b1;
    {req_write, req_addr, req_wdata, req_old, rd_pw_ok, wr_pw_ok, cfg_pw_ok} = v[31:3];
    exp = {1'b1, v[2:0], v[2] & v[31], v[2] & ~v[31]};
    @(negedge clk);
    req_valid = 1'b0;
    check(req, outs(), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_old = '0; rd_pw_ok = 1'b0; wr_pw_ok = 1'b0; cfg_pw_ok = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", outs(), 6'b0);
    rst_n = 1'b1;

    // R2 with reset codes every region is open: region 3 write with no flags
    request({1'b1, 9'h1C0, 8'hFF, 8'h00, 3'b000, 3'b100}, "R2 reset codes open");

    // R2 region codes: r0=0x0, r1=0x9 (wr pw, program), r2=0x6 (rd pw, read-only), r3=0x3 (locked)
    cfg_write(1'b0, 8'h90);
    cfg_write(1'b1, 8'h36);

    for (int i = 0; i < NV; i++) begin
      request(VEC[i], $sformatf("R1/R3/R4/R5/R6/R7 vector %0d", i));
    end

    // R8 decision lasts one cycle and idles with no request
    @(negedge clk);
    check("R8 idle after request", outs(), 6'b0);

    // R8 back-to-back requests each decided in the following cycle
    @(negedge clk);
    req_valid = 1'b1;
    {req_write, req_addr, req_wdata, req_old, rd_pw_ok, wr_pw_ok, cfg_pw_ok} =
      {1'b0, 9'h100, 8'h00, 8'h00, 3'b000};
    @(negedge clk);
    check("R8 first of pair", outs(), 6'b101000);
    {req_write, req_addr, req_wdata, req_old, rd_pw_ok, wr_pw_ok, cfg_pw_ok} =
      {1'b0, 9'h000, 8'h00, 8'h00, 3'b000};
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second of pair", outs(), 6'b110001);

    // R2 reload word 1: region 2 becomes program-only with no password (high nibble 0, low nibble 1)
    cfg_write(1'b1, 8'h01);
    request({1'b1, 9'h100, 8'h80, 8'h00, 3'b000, 3'b011}, "R2 R5 reloaded region 2 raise");
    request({1'b1, 9'h180, 8'hFF, 8'h00, 3'b000, 3'b100}, "R2 reloaded region 3 open");
    // R2 word 0 untouched by word 1 load: region 1 still needs write password
    request({1'b1, 9'h080, 8'h00, 8'h00, 3'b101, 3'b010}, "R2 word 0 kept");

    // R9 asynchronous reset clears outputs and codes
    @(negedge clk);
    req_valid = 1'b1;
    {req_write, req_addr, req_wdata, req_old, rd_pw_ok, wr_pw_ok, cfg_pw_ok} =
      {1'b1, 9'h080, 8'h00, 8'h00, 3'b000};
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    #1;
    check("R9 async reset", outs(), 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    request({1'b1, 9'h080, 8'hFF, 8'h00, 3'b000, 3'b100}, "R9 codes cleared by reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule